// File: doc/BRIEF.md
# Indirect Channel Configuration Access Controller

This block holds a per-channel configuration store of 2**CHAN_W entries, 256 by default. A host reaches the store only through two 16-bit registers on a simple synchronous register bus. The select register holds a channel index, a direction bit and a read-only busy flag. The data register carries one configuration word. Each write to the select register launches one access to the chosen entry. A read fetches that entry into the data register. A write stores the current data register contents into the entry.

The store has an access latency of LAT clock cycles. While an access is in flight the busy flag stays high, and any further command is refused. The host polls busy until it reads 0 before it takes a fetched word or issues the next command. A small sequencer with three states controls each access:

- `ST_IDLE` is the rest state. It moves to `ST_RD_PEND` on a command with direction 1, or to `ST_WR_PEND` on a command with direction 0.
- `ST_RD_PEND` and `ST_WR_PEND` both return to `ST_IDLE` when the store signals completion.

Top module: `cfg_ind_access`

## Requirements
- R1: After reset, the select register (offset 0x400) and the data register (offset 0x404) both read 0x0000, so busy reads 0.
- R2: After an access completes, the select register reads back bits 7:0 as the channel index and bit 14 as the direction bit of the command that launched it. Channel 0x00 is the first entry and 0xFF is the last.
- R3: In the first cycle after the clock edge that accepts a select-register write, bit 15 (busy) reads 1.
- R4: A command with bit 14 = 1 (read) loads the selected entry into the data register by the time busy returns to 0.
- R5: A command with bit 14 = 0 (write) stores the data register value into the selected entry. A later read of that channel returns the stored value.
- R6: Busy stays high for exactly LAT consecutive cycles per access, for both reads and writes.
- R7: Bit 15 ignores host writes. Writing it as 1 neither forces busy nor stops it from clearing.
- R8: A select-register write while busy is 1 is ignored. The index and direction of the access in flight stay unchanged, no second access starts, and the entry named by the refused write keeps its contents.
- R9: A data-register write while a read is in flight is ignored, and the data register ends up holding the fetched entry.
- R10: Select-register bits 13:8 always read 0, whatever was written to them.
- R11: Offsets other than 0x400 and 0x404 read 0x0000, and writes to them change neither register.
- R12: During a write access the data register stays writable. The entry receives the value the data register held when the command was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe, one cycle per write |
| host_addr | input | ADDR_W (12) | Register byte offset |
| host_wdata | input | DATA_W (16) | Register write data |
| host_rdata | output | DATA_W (16) | Read data for host_addr (combinational) |

## Verification
The hardest situations to reach are the collisions: a command or a data write arriving while an access is still inside its LAT-cycle window. The bench reaches them by issuing the second bus write two cycles after the launching one, which default latency places well inside the busy window. It then checks the outcome through ordinary register reads and follow-up read commands. The store itself is covered by a full sweep that writes an arithmetic pattern into all 256 entries and reads every entry back. Each of those accesses also has its busy window counted.

// File: rtl/cfg_ind_pkg.sv
package cfg_ind_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_PEND = 2'd1,
        ST_WR_PEND = 2'd2
    } acc_state_t;

    // Select register bit positions that the host software decodes
    localparam int SEL_DIR_BIT  = 14;
    localparam int SEL_BUSY_BIT = 15;

endpackage

// File: rtl/cfg_ind_ram.sv
// Configuration store with a fixed multi-cycle access latency.
module cfg_ind_ram #(
    parameter int CHAN_W = 8,
    parameter int DATA_W = 16,
    parameter int LAT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [CHAN_W-1:0] req_idx,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << CHAN_W;
    localparam int CNT_W = $clog2(LAT + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [CHAN_W-1:0] idx_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;

    // Latency counter: loaded on request, completion when it reaches one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (req) begin
            cnt_q   <= CNT_W'(LAT);
            idx_q   <= req_idx;
            we_q    <= req_we;
            wdata_q <= req_wdata;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign ack = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (ack && we_q) begin
            mem[idx_q] <= wdata_q;
        end
    end

    assign rdata = mem[idx_q];

endmodule

// File: rtl/cfg_ind_fsm.sv
// Access sequencer: idle, read pending, write pending.
module cfg_ind_fsm
    import cfg_ind_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic       cmd_rd_dir,
    input  logic       ram_ack,
    output logic       ram_req,
    output logic       ram_we,
    output logic       busy,
    output logic       rd_pend,
    output logic       load_data,
    output acc_state_t state
);

    acc_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_wr) begin
                    state_d = cmd_rd_dir ? ST_RD_PEND : ST_WR_PEND;
                end
            end
            ST_RD_PEND: begin
                if (ram_ack) state_d = ST_IDLE;
            end
            ST_WR_PEND: begin
                if (ram_ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ram_req   = 1'b0;
        ram_we    = 1'b0;
        busy      = 1'b1;
        rd_pend   = 1'b0;
        load_data = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy    = 1'b0;
                ram_req = cmd_wr;
                ram_we  = !cmd_rd_dir;
            end
            ST_RD_PEND: begin
                rd_pend   = 1'b1;
                load_data = ram_ack;
            end
            ST_WR_PEND: begin
                rd_pend = 1'b0;
            end
            default: busy = 1'b0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/cfg_ind_regs.sv
// Host-visible select and data registers with address decode.
module cfg_ind_regs
    import cfg_ind_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter int              CHAN_W   = 8,
    parameter int              DATA_W   = 16,
    parameter logic [ADDR_W-1:0] SEL_OFS  = 12'h400,
    parameter logic [ADDR_W-1:0] DATA_OFS = 12'h404
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              busy,
    input  logic              rd_pend,
    input  logic              load_data,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              sel_wr,
    output logic              sel_dir,
    output logic [CHAN_W-1:0] chan_q,
    output logic              dir_q,
    output logic [DATA_W-1:0] data_q
);

    logic data_wr;

    assign sel_wr  = host_wr && (host_addr == SEL_OFS);
    assign data_wr = host_wr && (host_addr == DATA_OFS);
    assign sel_dir = host_wdata[SEL_DIR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
            dir_q  <= 1'b0;
            data_q <= '0;
        end else begin
            if (sel_wr && !busy) begin
                chan_q <= host_wdata[CHAN_W-1:0];
                dir_q  <= host_wdata[SEL_DIR_BIT];
            end
            if (load_data) begin
                data_q <= ram_rdata;
            end else if (data_wr && !rd_pend) begin
                data_q <= host_wdata;
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_addr == SEL_OFS) begin
            host_rdata[CHAN_W-1:0]   = chan_q;
            host_rdata[SEL_DIR_BIT]  = dir_q;
            host_rdata[SEL_BUSY_BIT] = busy;
        end else if (host_addr == DATA_OFS) begin
            host_rdata = data_q;
        end
    end

endmodule

// File: rtl/cfg_ind_access.sv
// Top: indirect host access to the per-channel configuration store.
module cfg_ind_access
    import cfg_ind_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                CHAN_W   = 8,
    parameter int                DATA_W   = 16,
    parameter int                LAT      = 4,
    parameter logic [ADDR_W-1:0] SEL_OFS  = 12'h400,
    parameter logic [ADDR_W-1:0] DATA_OFS = 12'h404
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);

    logic              sel_wr;
    logic              sel_dir;
    logic              busy;
    logic              rd_pend;
    logic              load_data;
    logic              ram_req;
    logic              ram_we;
    logic              ram_ack;
    logic [DATA_W-1:0] ram_rdata;
    logic [CHAN_W-1:0] chan_q;
    logic              dir_q;
    logic [DATA_W-1:0] data_q;
    acc_state_t        state;

    cfg_ind_regs #(
        .ADDR_W  (ADDR_W),
        .CHAN_W  (CHAN_W),
        .DATA_W  (DATA_W),
        .SEL_OFS (SEL_OFS),
        .DATA_OFS(DATA_OFS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .busy      (busy),
        .rd_pend   (rd_pend),
        .load_data (load_data),
        .ram_rdata (ram_rdata),
        .sel_wr    (sel_wr),
        .sel_dir   (sel_dir),
        .chan_q    (chan_q),
        .dir_q     (dir_q),
        .data_q    (data_q)
    );

    cfg_ind_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (sel_wr),
        .cmd_rd_dir(sel_dir),
        .ram_ack   (ram_ack),
        .ram_req   (ram_req),
        .ram_we    (ram_we),
        .busy      (busy),
        .rd_pend   (rd_pend),
        .load_data (load_data),
        .state     (state)
    );

    cfg_ind_ram #(
        .CHAN_W(CHAN_W),
        .DATA_W(DATA_W),
        .LAT   (LAT)
    ) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (ram_req),
        .req_we   (ram_we),
        .req_idx  (host_wdata[CHAN_W-1:0]),
        .req_wdata(data_q),
        .ack      (ram_ack),
        .rdata    (ram_rdata)
    );

endmodule

// File: rtl/cfg_ind_checker.sv
module cfg_ind_checker
    import cfg_ind_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                CHAN_W   = 8,
    parameter int                DATA_W   = 16,
    parameter int                LAT      = 4,
    parameter logic [ADDR_W-1:0] SEL_OFS  = 12'h400
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_rdata,
    input logic              busy,
    input logic              rd_pend,
    input logic [CHAN_W-1:0] chan_q,
    input logic              dir_q,
    input logic [DATA_W-1:0] data_q
);

    int unsigned busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    AST_BUSY_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_wr && host_addr == SEL_OFS) |=> busy); // R3

    AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_run == LAT); // R6

    AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> ($stable(chan_q) && $stable(dir_q))); // R8

    AST_DATA_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_pend) && rd_pend) |-> $stable(data_q)); // R9

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == SEL_OFS) |-> (host_rdata[SEL_DIR_BIT-1:CHAN_W] == '0)); // R10

endmodule

bind cfg_ind_access cfg_ind_checker #(
    .ADDR_W (ADDR_W),
    .CHAN_W (CHAN_W),
    .DATA_W (DATA_W),
    .LAT    (LAT),
    .SEL_OFS(SEL_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_rdata(host_rdata),
    .busy      (busy),
    .rd_pend   (rd_pend),
    .chan_q    (chan_q),
    .dir_q     (dir_q),
    .data_q    (data_q)
);

// File: tb/test_cfg_ind_access.sv
module test_cfg_ind_access;

    localparam int          LAT  = 4;
    localparam logic [11:0] SEL  = 12'h400;
    localparam logic [11:0] DAT  = 12'h404;
    localparam logic [11:0] OTH  = 12'h408;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [11:0] host_addr = SEL;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cfg_ind_access #(.LAT(LAT)) i_cfg_ind_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    function automatic logic [15:0] pat(input int i);
        pat = 16'((i * 40503 + 499) ^ (i << 7));
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [15:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    // Counts cycles with busy high, starting right after a launching write
    task automatic wait_idle(output int cyc);
        cyc = 0;
        host_addr = SEL;
        #1;
        while (host_rdata[15]) begin
            cyc++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic access(input logic [15:0] selv, output int cyc);
        logic [15:0] v;
        bus_write(SEL, selv);
        bus_read(SEL, v);
        chk("R3 busy after launch", 16'(v[15]), 16'd1);
        wait_idle(cyc);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int cyc;
        repeat (3) @(negedge clk);
        bus_read(SEL, v); chk("R1 select after reset", v, 16'h0000);
        bus_read(DAT, v); chk("R1 data after reset", v, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(SEL, v); chk("R1 select idle", v, 16'h0000);

        // R5: fill every entry with the pattern, counting busy (R6)
        for (int i = 0; i < 256; i++) begin
            bus_write(DAT, pat(i));
            access(16'(i), cyc);
            chk("R6 write busy cycles", 16'(cyc), 16'(LAT));
        end
        // R4/R2: read every entry back
        for (int i = 0; i < 256; i++) begin
            access(16'h4000 | 16'(i), cyc);
            chk("R6 read busy cycles", 16'(cyc), 16'(LAT));
            bus_read(SEL, v); chk("R2 select readback", v, 16'h4000 | 16'(i));
            bus_read(DAT, v); chk("R4 R5 entry readback", v, pat(i));
        end

        // R8: command while busy is refused
        bus_write(SEL, 16'h4005);
        bus_write(SEL, 16'h0009);
        wait_idle(cyc);
        bus_read(SEL, v); chk("R8 select kept", v, 16'h4005);
        bus_read(DAT, v); chk("R8 in-flight read intact", v, pat(5));
        access(16'h4009, cyc);
        bus_read(DAT, v); chk("R8 refused write had no effect", v, pat(9));

        // R9: data write during read is refused
        bus_write(SEL, 16'h4007);
        bus_write(DAT, 16'hDEAD);
        wait_idle(cyc);
        bus_read(DAT, v); chk("R9 data holds fetched entry", v, pat(7));

        // R12: data write during write access allowed, entry gets launch value
        bus_write(DAT, 16'h1234);
        bus_write(SEL, 16'h0003);
        bus_write(DAT, 16'hBEEF);
        wait_idle(cyc);
        bus_read(DAT, v); chk("R12 data writable during write", v, 16'hBEEF);
        access(16'h4003, cyc);
        bus_read(DAT, v); chk("R12 entry holds launch value", v, 16'h1234);

        // R7: writing bit 15 does not force busy
        bus_write(DAT, 16'h0F0F);
        access(16'h8011, cyc);
        chk("R7 busy still ends after LAT", 16'(cyc), 16'(LAT));
        bus_read(SEL, v); chk("R7 busy reads 0 afterwards", v, 16'h0011);
        access(16'h4011, cyc);
        bus_read(DAT, v); chk("R7 write performed", v, 16'h0F0F);

        // R10: unused bits read 0
        access(16'h7F22, cyc);
        bus_read(SEL, v); chk("R10 unused bits zero", v, 16'h4022);
        bus_read(DAT, v); chk("R10 read of channel 0x22", v, pat(34));

        // R11: other offsets
        bus_write(OTH, 16'hFFFF);
        bus_read(OTH, v); chk("R11 other offset reads 0", v, 16'h0000);
        bus_read(SEL, v); chk("R11 select untouched", v, 16'h4022);
        bus_read(DAT, v); chk("R11 data untouched", v, pat(34));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule